// File: doc/BRIEF.md
# Interrupt Deferral Controller

This execute-stage control block decides when an interrupt found on an incoming instruction may be delivered to writeback. An example is a floating-point load arriving while the floating-point unit is disabled. The memory unit may still be working on older load/store instructions. An instruction that carries an interrupt condition is never issued, so it can never reach the memory unit. If the memory unit is idle, the interrupt request goes to writeback in the same cycle. If the memory unit is still busy, the request is parked in a pending flag together with its cause code. Decode is then held off through the busy output until the memory unit drains.

An older memory instruction can fault while a request is parked. In that case the memory unit pulses its interrupt strobe, and the parked request is thrown away, because the older fault takes precedence. The same rule applies when the strobe arrives in the cycle the condition is first seen. The block contains no vectors, no register writeback and no memory unit model. It only sequences the request.

Top module: `intr_defer_ctrl`

## Requirements
- R1: After synchronous active-low reset, busy_out and wb_intr_valid are 0 while the inputs are idle.
- R2: If in_valid and in_intr are high, no request is pending, and both mem_busy and mem_intr are low, then wb_intr_valid is 1 in the same cycle with wb_intr_cause equal to in_cause. busy_out stays 0 in the following cycle.
- R3: If in_valid and in_intr are high while mem_busy is 1 and mem_intr is 0, then wb_intr_valid is 0 in that cycle and busy_out is 1 from the next cycle.
- R4: While a request is pending and mem_busy stays 1, busy_out stays 1 and wb_intr_valid stays 0.
- R5: While a request is pending, a cycle with mem_busy and mem_intr both 0 raises wb_intr_valid in that cycle, with the captured cause. In the next cycle busy_out and wb_intr_valid are both 0.
- R6: While a request is pending, mem_intr=1 discards it: wb_intr_valid is 0 in that cycle and stays 0 afterwards, and busy_out is 0 from the next cycle.
- R7: issue_en is 0 in every cycle in which in_intr is 1.
- R8: With no request pending, an instruction with in_valid=1 and in_intr=0 gets issue_en=1 in the same cycle. With in_valid=0, issue_en is 0.
- R9: If mem_intr is 1 in the cycle a condition is detected, no request is sent to writeback and none is parked, so busy_out is 0 in the next cycle.
- R10: While a request is pending, input instructions are ignored: issue_en is 0, and the cause forwarded later is the one captured at detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming instruction valid |
| in_intr | input | 1 | Incoming instruction must take an interrupt |
| in_cause | input | CAUSE_W | Cause code of that interrupt |
| mem_busy | input | 1 | Memory unit still holds older instructions |
| mem_intr | input | 1 | Memory unit raises its own interrupt |
| busy_out | output | 1 | Stall toward decode |
| issue_en | output | 1 | Incoming instruction may be executed |
| wb_intr_valid | output | 1 | Interrupt request toward writeback |
| wb_intr_cause | output | CAUSE_W | Cause code of the request |

## Verification
issue_en and wb_intr_valid are combinational, so they are due in the same cycle as the input pattern that causes them. busy_out comes from the pending register and changes one clock edge after detection, release or discard. The bench changes inputs on the falling edge and samples the same-cycle results 2 ns later, before the next rising edge. It samples busy_out, and the cleared request that follows a release, at the next falling edge, after exactly one register update.

// File: rtl/intr_defer_pkg.sv
// Package: shared types for the interrupt deferral controller.
// Assumes: one flag update operation per cycle.
package intr_defer_pkg;
    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_op_e;
endpackage

// File: rtl/intr_defer_flag.sv
// Module: holds the pending-interrupt flag and its captured cause code.
// Assumes: op comes from the decision logic; FLAG_SET captures set_cause.
module intr_defer_flag
    import intr_defer_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  flag_op_e           op,
    input  logic [CAUSE_W-1:0] set_cause,
    input  logic               mem_busy,
    input  logic               mem_intr,
    output logic               pend,
    output logic [CAUSE_W-1:0] pend_cause
);
    // Pending flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            case (op)
                FLAG_SET:   pend <= 1'b1;
                FLAG_CLEAR: pend <= 1'b0;
                default:    pend <= pend;
            endcase
        end
    end

    // Cause capture, loaded only when the flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cause <= '0;
        end else if (op == FLAG_SET) begin
            pend_cause <= set_cause;
        end
    end

    // R6: a memory-unit interrupt always leaves the flag clear.
    assert_drop_on_mem_intr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend && mem_intr |=> !pend);
    // R5: a drained memory unit releases the flag.
    assert_release_on_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !mem_busy && !mem_intr |=> !pend);
    // R10: captured cause does not move while pending.
    assert_cause_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend && $past(pend) |-> $stable(pend_cause));
endmodule

// File: rtl/intr_defer_gate.sv
// Module: combinational decision logic for issue, forwarding and flag updates.
// Assumes: pend and pend_cause come from intr_defer_flag, and mem_intr means
// an older memory instruction faulted this cycle.
module intr_defer_gate
    import intr_defer_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_intr,
    input  logic [CAUSE_W-1:0] in_cause,
    input  logic               mem_busy,
    input  logic               mem_intr,
    input  logic               pend,
    input  logic [CAUSE_W-1:0] pend_cause,
    output flag_op_e           op,
    output logic               issue_en,
    output logic               busy,
    output logic               wb_valid,
    output logic [CAUSE_W-1:0] wb_cause
);
    logic detect;
    logic drained;

    // Classify this cycle: new condition seen, memory unit free of work.
    always_comb begin
        detect  = in_valid && in_intr && !pend;
        drained = !mem_busy && !mem_intr;
    end

    // Issue only clean instructions when nothing is parked.
    always_comb begin
        issue_en = in_valid && !in_intr && !pend;
        busy     = pend;
    end

    // Forward a request to writeback, either parked or fresh.
    always_comb begin
        wb_valid = (pend || detect) && drained;
        wb_cause = pend ? pend_cause : in_cause;
    end

    // Choose the flag update for the next edge.
    always_comb begin
        if (mem_intr) begin
            op = FLAG_CLEAR;
        end else if (pend && !mem_busy) begin
            op = FLAG_CLEAR;
        end else if (detect && mem_busy) begin
            op = FLAG_SET;
        end else begin
            op = FLAG_HOLD;
        end
    end

    // R7: an instruction carrying an interrupt is never issued.
    assert_no_issue_on_intr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_intr |-> !issue_en);
    // R9: memory fault wins over a fresh condition.
    assert_no_forward_on_mem_intr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_intr |-> !wb_valid);
endmodule

// File: rtl/intr_defer_ctrl.sv
// Module: top of the interrupt deferral controller.
// Holds an interrupt request back while the memory unit is busy, stalls decode,
// and forwards or discards the request when the memory unit drains or faults.
// Assumes: decode honours busy_out in the cycle after it rises.
module intr_defer_ctrl
    import intr_defer_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_intr,
    input  logic [CAUSE_W-1:0] in_cause,
    input  logic               mem_busy,
    input  logic               mem_intr,
    output logic               busy_out,
    output logic               issue_en,
    output logic               wb_intr_valid,
    output logic [CAUSE_W-1:0] wb_intr_cause
);
    flag_op_e           op;
    logic               pend;
    logic [CAUSE_W-1:0] pend_cause;

    intr_defer_gate #(.CAUSE_W(CAUSE_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_intr    (in_intr),
        .in_cause   (in_cause),
        .mem_busy   (mem_busy),
        .mem_intr   (mem_intr),
        .pend       (pend),
        .pend_cause (pend_cause),
        .op         (op),
        .issue_en   (issue_en),
        .busy       (busy_out),
        .wb_valid   (wb_intr_valid),
        .wb_cause   (wb_intr_cause)
    );

    intr_defer_flag #(.CAUSE_W(CAUSE_W)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .set_cause  (in_cause),
        .mem_busy   (mem_busy),
        .mem_intr   (mem_intr),
        .pend       (pend),
        .pend_cause (pend_cause)
    );

    // R3: a deferred detection stalls decode on the next cycle.
    assert_stall_after_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_intr && !busy_out && mem_busy && !mem_intr |=> busy_out);
    // R4: while stalled and memory stays busy, nothing reaches writeback.
    assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_out && mem_busy |-> !wb_intr_valid);
    // R5: a stalled request is forwarded when memory drains.
    assert_forward_on_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_out && !mem_busy && !mem_intr |-> wb_intr_valid);
endmodule

// File: tb/sim_intr_defer_ctrl.sv
// Bench: directed scenarios, each task checks its own results.
module sim_intr_defer_ctrl;
    localparam int CW = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_intr = 1'b0, mem_busy = 1'b0, mem_intr = 1'b0;
    logic [CW-1:0] in_cause = '0;
    logic busy_out, issue_en, wb_intr_valid;
    logic [CW-1:0] wb_intr_cause;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    intr_defer_ctrl #(.CAUSE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_intr(in_intr),
        .in_cause(in_cause), .mem_busy(mem_busy), .mem_intr(mem_intr),
        .busy_out(busy_out), .issue_en(issue_en),
        .wb_intr_valid(wb_intr_valid), .wb_intr_cause(wb_intr_cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic i, input logic [CW-1:0] c,
                         input logic mb, input logic mi);
        @(negedge clk);
        in_valid = v; in_intr = i; in_cause = c; mem_busy = mb; mem_intr = mi;
        #2;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0);
        chk("R1 busy", busy_out, 0);
        chk("R1 wb", wb_intr_valid, 0);
    endtask

    task automatic t_clean_issue;
        drive(1, 0, 3, 1, 0);
        chk("R8 issue", issue_en, 1);
        drive(0, 0, 3, 0, 0);
        chk("R8 idle", issue_en, 0);
    endtask

    task automatic t_immediate;
        drive(1, 1, 4'd6, 0, 0);
        chk("R2 wb", wb_intr_valid, 1);
        chk("R2 cause", wb_intr_cause, 6);
        chk("R7 issue", issue_en, 0);
        drive(0, 0, 0, 0, 0);
        chk("R2 busy", busy_out, 0);
        chk("R2 wb after", wb_intr_valid, 0);
    endtask

    task automatic t_defer_release;
        drive(1, 1, 4'd5, 1, 0);
        chk("R3 wb", wb_intr_valid, 0);
        chk("R7 issue", issue_en, 0);
        drive(1, 1, 4'd9, 1, 0);
        chk("R3 busy", busy_out, 1);
        chk("R10 issue", issue_en, 0);
        drive(1, 0, 4'd2, 1, 0);
        chk("R4 busy", busy_out, 1);
        chk("R4 wb", wb_intr_valid, 0);
        chk("R10 issue clean", issue_en, 0);
        drive(0, 0, 0, 0, 0);
        chk("R5 wb", wb_intr_valid, 1);
        chk("R10 cause", wb_intr_cause, 5);
        drive(0, 0, 0, 0, 0);
        chk("R5 busy", busy_out, 0);
        chk("R5 wb after", wb_intr_valid, 0);
    endtask

    task automatic t_discard;
        drive(1, 1, 4'd7, 1, 0);
        drive(0, 0, 0, 1, 1);
        chk("R6 busy before", busy_out, 1);
        chk("R6 wb", wb_intr_valid, 0);
        drive(0, 0, 0, 0, 0);
        chk("R6 busy", busy_out, 0);
        chk("R6 wb after", wb_intr_valid, 0);
    endtask

    task automatic t_same_cycle_fault;
        drive(1, 1, 4'd3, 1, 1);
        chk("R9 wb busy-mem", wb_intr_valid, 0);
        drive(0, 0, 0, 0, 0);
        chk("R9 busy", busy_out, 0);
        chk("R9 wb", wb_intr_valid, 0);
        drive(1, 1, 4'd4, 0, 1);
        chk("R9 wb idle-mem", wb_intr_valid, 0);
        drive(0, 0, 0, 0, 0);
        chk("R9 busy idle-mem", busy_out, 0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_clean_issue();
        t_immediate();
        t_defer_release();
        t_discard();
        t_same_cycle_fault();
        t_defer_release();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule